// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Hardware Table Walk

This block turns 31-bit virtual byte addresses from load and store requests into 27-bit physical addresses using 4 KB pages. The lower 12 bits never change. The upper 19 bits form the virtual page number, and a small fully associative translation cache maps that number to a 15-bit physical page number. When the cache holds the page, and the request is a load or the cached entry is already marked modified, the answer comes back on the next cycle and memory is not touched.

In every other case a walker reads the page tables through a single memory port. The virtual page number is split into a 9-bit upper index into a 512-entry first-level table and a 10-bit lower index into a 1024-entry second-level table. The first-level table starts at an address given on an input. Each level carries a valid bit. A missing level, or a store to a page that does not allow writes, produces a fault response that carries a code and the faulting virtual address. A walk that succeeds writes the leaf entry back with its accessed bit set, and with its modified bit set for a store. It then refills the cache and answers.

Only one request is in flight at a time. A flush input clears every cached translation.

Top module: `mmu_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `resp_valid`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: A successful response has `resp_paddr` = {physical page number, `resp_vaddr`[11:0]`}`. `resp_vaddr` echoes the accepted request address on every response.
- R3: A load whose page is cached, or a store whose cached entry has its modified flag set, responds in the cycle after acceptance and issues no memory access. It uses the cached page number even if the table in memory has since changed.
- R4: A walk issues two reads. The first is at `pt_base + idx1*4`, where idx1 = VA[30:22]. The second is at `L1[26:0] + idx2*4`, where idx2 = VA[21:12]. Both table levels hold 32-bit entries with the valid flag in bit 31; a first-level entry holds the second-level table base in bits [26:0]. With memory returning data (`mem_rvalid`) one cycle after each read, a successful walk responds 6 cycles after acceptance.
- R5: A first-level entry with bit 31 clear gives a fault with `resp_code` 1, 3 cycles after acceptance, after only one read.
- R6: A second-level entry with bit 31 clear gives a fault with `resp_code` 2, 5 cycles after acceptance.
- R7: A store to a page whose leaf entry has its write-enable bit (bit 28) clear gives a fault with `resp_code` 3, 5 cycles after acceptance. The leaf entry in memory is left unchanged.
- R8: A successful walk writes the leaf entry back to the same address once. The write sets the accessed bit (bit 30), sets the modified bit (bit 29) for a store, and keeps every other bit. The physical page number is leaf bits [14:0].
- R9: A store that finds its page cached with the modified flag clear performs a full walk. After that walk, a store to the same page hits.
- R10: A pulse on `flush` empties the translation cache, so the next access to any page walks.
- R11: The cache holds `TLB_N` (8) pages and refills new pages in round-robin slot order. A refill of a page that is already cached overwrites its own slot.
- R12: `req_ready` is 0 from the cycle after acceptance through the single response cycle, and is 1 again in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_base | input | 27 | Physical byte address of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_store | input | 1 | Request is a store (1) or a load (0) |
| req_vaddr | input | 31 | Virtual byte address |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Response is a fault |
| resp_code | output | 2 | 0 none, 1 first level missing, 2 page missing, 3 write protected |
| resp_paddr | output | 27 | Translated physical address |
| resp_vaddr | output | 31 | Virtual address the response belongs to |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_wr_en | output | 1 | Page-table write strobe |
| mem_addr | output | 27 | Page-table entry address |
| mem_wdata | output | 32 | Entry written back |
| mem_rdata | input | 32 | Entry read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
Some properties are checked on every cycle: the request handshake and the single-cycle response, that a hit answers on the next cycle with no memory read, that a successful answer keeps the page offset, that a fault always carries a non-zero code, and that every write-back has the valid and accessed bits set. Other behaviour only shows up in the bench scenarios: the exact addresses walked, the fault latency at each level, the memory contents after a write-back or a refused store, the stale-hit behaviour, flushing, and which slot the round-robin refill evicts.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int VA_W  = 31;
  localparam int PA_W  = 27;
  localparam int OFF_W = 12;
  localparam int L1_W  = 9;
  localparam int L2_W  = 10;
  localparam int VPN_W = L1_W + L2_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int PTE_W = 32;

  // entry flag positions (shared by both table levels where meaningful)
  localparam int B_VLD = 31;
  localparam int B_USE = 30;
  localparam int B_DRT = 29;
  localparam int B_WEN = 28;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_L1   = 2'd1,
    FC_L2   = 2'd2,
    FC_WP   = 2'd3
  } fcode_e;

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [L1_W-1:0] hi_idx(input logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1:L2_W];
  endfunction

  function automatic logic [L2_W-1:0] lo_idx(input logic [VPN_W-1:0] vpn);
    return vpn[L2_W-1:0];
  endfunction

  // table base plus a word index
  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [L2_W-1:0] idx);
    return base + PA_W'({idx, 2'b00});
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [VA_W-1:0] va);
    return {ppn, va[OFF_W-1:0]};
  endfunction

  // mark accessed, and modified for a store
  function automatic logic [PTE_W-1:0] touch(input logic [PTE_W-1:0] pte,
                                             input logic st);
    logic [PTE_W-1:0] r;
    r = pte;
    r[B_USE] = 1'b1;
    if (st) r[B_DRT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb
  import mmu_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_en,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_dirty
);
  logic [N-1:0]     vld;
  logic [N-1:0]     match;
  logic [N-1:0]     drt;
  logic [VPN_W-1:0] tag [N];
  logic [PPN_W-1:0] ppn [N];
  logic [IW-1:0]    rr;
  logic [N-1:0]     slot_sel;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g]    = vld[g] && (tag[g] == lk_vpn);
    assign slot_sel[g] = hit ? match[g] : (rr == IW'(g));
  end

  assign hit = |match;

  always_comb begin
    hit_ppn   = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit_ppn   = hit_ppn | ppn[i];
        hit_dirty = hit_dirty | drt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (fill_en) begin
      vld <= vld | slot_sel;
      if (!hit) rr <= (rr == IW'(N - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      for (int i = 0; i < N; i++) begin
        if (slot_sel[i]) begin
          tag[i] <= lk_vpn;
          ppn[i] <= fill_ppn;
          drt[i] <= fill_dirty;
        end
      end
    end
  end
endmodule

// File: rtl/mmu_walker.sv
module mmu_walker
  import mmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             store,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PA_W-1:0]  pt_base,
  input  logic [PTE_W-1:0] mem_rdata,
  input  logic             mem_rvalid,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  output logic             fill_en,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             fill_dirty,
  output logic             done,
  output logic             fault,
  output fcode_e           code,
  output logic [PA_W-1:0]  paddr
);
  typedef enum logic [2:0] {
    W_IDLE, W_RD1, W_WT1, W_RD2, W_WT2, W_UPD, W_OK, W_FLT
  } wst_e;

  wst_e             st;
  logic [VA_W-1:0]  va_q;
  logic             str_q;
  logic [PA_W-1:0]  tbl_q;
  logic [PTE_W-1:0] pte_q;
  fcode_e           code_q;
  logic [VPN_W-1:0] vpn;
  logic [PA_W-1:0]  addr1, addr2;

  assign vpn   = vpn_of(va_q);
  assign addr1 = entry_addr(pt_base, L2_W'(hi_idx(vpn)));
  assign addr2 = entry_addr(tbl_q, lo_idx(vpn));

  assign mem_rd_en  = (st == W_RD1) || (st == W_RD2);
  assign mem_wr_en  = (st == W_UPD);
  assign mem_addr   = (st == W_RD1) ? addr1 : addr2;
  assign mem_wdata  = touch(pte_q, str_q);
  assign fill_en    = (st == W_UPD);
  assign fill_ppn   = pte_q[PPN_W-1:0];
  assign fill_dirty = mem_wdata[B_DRT];
  assign done       = (st == W_OK) || (st == W_FLT);
  assign fault      = (st == W_FLT);
  assign code       = code_q;
  assign paddr      = join_pa(pte_q[PPN_W-1:0], va_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      code_q <= FC_NONE;
      va_q   <= '0;
      str_q  <= 1'b0;
      tbl_q  <= '0;
      pte_q  <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (start) begin
          va_q   <= vaddr;
          str_q  <= store;
          code_q <= FC_NONE;
          st     <= W_RD1;
        end
        W_RD1: st <= W_WT1;
        W_WT1: if (mem_rvalid) begin
          if (!mem_rdata[B_VLD]) begin
            code_q <= FC_L1;
            st     <= W_FLT;
          end else begin
            tbl_q <= mem_rdata[PA_W-1:0];
            st    <= W_RD2;
          end
        end
        W_RD2: st <= W_WT2;
        W_WT2: if (mem_rvalid) begin
          pte_q <= mem_rdata;
          if (!mem_rdata[B_VLD]) begin
            code_q <= FC_L2;
            st     <= W_FLT;
          end else if (str_q && !mem_rdata[B_WEN]) begin
            code_q <= FC_WP;
            st     <= W_FLT;
          end else begin
            st <= W_UPD;
          end
        end
        W_UPD:  st <= W_OK;
        W_OK:   st <= W_IDLE;
        W_FLT:  st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int TLB_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PA_W-1:0]  pt_base,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [1:0]       resp_code,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [VA_W-1:0]  resp_vaddr,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic [PTE_W-1:0] mem_rdata,
  input  logic             mem_rvalid
);
  logic             busy_q, hit_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  hpa_q;
  logic [VPN_W-1:0] lk_vpn;
  logic             tlb_hit, tlb_dirty;
  logic [PPN_W-1:0] tlb_ppn;
  logic             accept, hit_ok, walk_start;
  logic             w_done, w_fault;
  fcode_e           w_code;
  logic [PA_W-1:0]  w_paddr;
  logic             fill_en, fill_dirty;
  logic [PPN_W-1:0] fill_ppn;

  // while busy the lookup port tracks the request in flight (for refill)
  assign lk_vpn     = busy_q ? vpn_of(va_q) : vpn_of(req_vaddr);
  assign accept     = req_valid && !busy_q;
  assign hit_ok     = tlb_hit && (!req_store || tlb_dirty);
  assign walk_start = accept && !hit_ok;

  mmu_tlb #(.N(TLB_N)) u_tlb (
    .clk, .rst_n, .flush,
    .lk_vpn, .fill_en, .fill_ppn, .fill_dirty,
    .hit(tlb_hit), .hit_ppn(tlb_ppn), .hit_dirty(tlb_dirty)
  );

  mmu_walker u_walk (
    .clk, .rst_n,
    .start(walk_start), .store(req_store), .vaddr(req_vaddr), .pt_base,
    .mem_rdata, .mem_rvalid, .mem_rd_en, .mem_wr_en, .mem_addr, .mem_wdata,
    .fill_en, .fill_ppn, .fill_dirty,
    .done(w_done), .fault(w_fault), .code(w_code), .paddr(w_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hit_q  <= 1'b0;
      va_q   <= '0;
      hpa_q  <= '0;
    end else begin
      hit_q <= accept && hit_ok;
      if (accept) begin
        busy_q <= 1'b1;
        va_q   <= req_vaddr;
        hpa_q  <= join_pa(tlb_ppn, req_vaddr);
      end else if (resp_valid) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign req_ready  = !busy_q;
  assign resp_valid = hit_q || w_done;
  assign resp_fault = w_done && w_fault;
  assign resp_code  = hit_q ? FC_NONE : w_code;
  assign resp_paddr = hit_q ? hpa_q : w_paddr;
  assign resp_vaddr = va_q;
endmodule

// File: rtl/mmu_xlate_sva.sv
module mmu_xlate_sva
  import mmu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_fault,
  input logic [1:0]       resp_code,
  input logic [PA_W-1:0]  resp_paddr,
  input logic [VA_W-1:0]  resp_vaddr,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [PTE_W-1:0] mem_wdata,
  input logic             accept,
  input logic             hit_ok
);
  a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit_ok |=> resp_valid && !resp_fault);

  a_r3_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit_ok |=> !mem_rd_en && !mem_wr_en);

  a_r12_ready_not_resp: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !resp_valid);

  a_r12_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault |-> resp_paddr[OFF_W-1:0] == resp_vaddr[OFF_W-1:0]);

  a_r4_one_port_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, mem_wr_en}));

  a_r5_fault_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_code != 2'd0);

  a_r8_writeback_flags: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wdata[B_USE] && mem_wdata[B_VLD]);
endmodule

bind mmu_xlate mmu_xlate_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_fault(resp_fault), .resp_code(resp_code), .resp_paddr(resp_paddr),
  .resp_vaddr(resp_vaddr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_wdata(mem_wdata), .accept(accept), .hit_ok(hit_ok)
);

// File: tb/sim_mmu_xlate.sv
module sim_mmu_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned BASE = 32'h0010000;
  localparam int unsigned TBL0 = 32'h0400000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [30:0] req_vaddr = '0;
  logic        req_ready, resp_valid, resp_fault;
  logic [1:0]  resp_code;
  logic [26:0] resp_paddr;
  logic [30:0] resp_vaddr;
  logic        mem_rd_en, mem_wr_en;
  logic [26:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  int checks = 0, errors = 0;
  bit in_txn = 0, started = 0;

  int unsigned pt[int unsigned];
  int unsigned rd_log[$];

  // behavioural cache model
  bit          m_v[8];
  int unsigned m_vpn[8], m_ppn[8];
  bit          m_d[8];
  int          m_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_xlate u0 (
    .clk, .rst_n, .flush, .pt_base(27'(BASE)), .req_valid, .req_store, .req_vaddr,
    .req_ready, .resp_valid, .resp_fault, .resp_code, .resp_paddr, .resp_vaddr,
    .mem_rd_en, .mem_wr_en, .mem_addr, .mem_wdata, .mem_rdata, .mem_rvalid
  );

  function automatic int unsigned rd(input int unsigned a);
    return pt.exists(a) ? pt[a] : 32'h0;
  endfunction

  // memory: answers one cycle after each read strobe
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd_en) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= rd(32'(mem_addr));
      rd_log.push_back(32'(mem_addr));
    end
    if (mem_wr_en) pt[32'(mem_addr)] = mem_wdata;
  end

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !in_txn) begin
      chk(!resp_valid && req_ready, "R12", "idle outputs", {resp_valid, req_ready}, 2'b01);
    end
  end

  task automatic map_page(input int unsigned vpn, input int unsigned ppn, input bit wen);
    int unsigned tb;
    tb = TBL0 + (vpn >> 10) * 32'h1000;
    pt[BASE + (vpn >> 10) * 4] = 32'h8000_0000 | tb;
    pt[tb + (vpn & 1023) * 4]  = 32'h8000_0000 | (32'(wen) << 28) | ppn;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    foreach (m_v[i]) m_v[i] = 0;
  endtask

  task automatic req(input int unsigned vpn, input int unsigned off, input bit st,
                     input string tag);
    int lat, code, hit_i, nrd;
    int unsigned ppn, a1, a2, p1, p2, newp, va;
    int unsigned ra[2];
    bit wr;
    hit_i = -1; wr = 0; code = 0; nrd = 0; ppn = 0; a2 = 0; p2 = 0; newp = 0;
    ra[0] = 0; ra[1] = 0;
    for (int i = 0; i < 8; i++)
      if (m_v[i] && m_vpn[i] == vpn && (!st || m_d[i])) hit_i = i;
    if (hit_i >= 0) begin
      lat = 1; ppn = m_ppn[hit_i];
    end else begin
      a1 = BASE + (vpn >> 10) * 4; ra[0] = a1; nrd = 1; p1 = rd(a1);
      if (!p1[31]) begin lat = 3; code = 1; end
      else begin
        a2 = (p1 & 32'h07FF_FFFF) + (vpn & 1023) * 4; ra[1] = a2; nrd = 2; p2 = rd(a2);
        if (!p2[31]) begin lat = 5; code = 2; end
        else if (st && !p2[28]) begin lat = 5; code = 3; end
        else begin
          lat = 6; wr = 1; ppn = p2 & 32'h7FFF;
          newp = p2 | 32'h4000_0000 | (st ? 32'h2000_0000 : 0);
        end
      end
    end
    va = (vpn << 12) | off;
    @(negedge clk);
    in_txn = 1; rd_log.delete();
    req_valid = 1'b1; req_store = st; req_vaddr = 31'(va);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= lat + 1; k++) begin
      if (k > 1) @(negedge clk);
      chk(resp_valid == (k == lat), tag, "resp_valid timing", resp_valid, k == lat);
      chk(req_ready == (k > lat), "R12", "req_ready", req_ready, k > lat);
      if (k == lat) begin
        chk(resp_fault == (code != 0), tag, "resp_fault", resp_fault, code != 0);
        chk(resp_code == code, tag, "resp_code", resp_code, code);
        chk(resp_vaddr == va, "R2", "resp_vaddr", resp_vaddr, va);
        if (code == 0)
          chk(resp_paddr == ((ppn << 12) | off), "R2", "resp_paddr", resp_paddr,
              (ppn << 12) | off);
      end
    end
    chk(rd_log.size() == nrd, (nrd == 0) ? "R3" : "R4", "read count", rd_log.size(), nrd);
    for (int i = 0; i < nrd && i < rd_log.size(); i++)
      chk(rd_log[i] == ra[i], "R4", "read address", rd_log[i], ra[i]);
    if (wr) chk(rd(a2) == newp, "R8", "write-back entry", rd(a2), newp);
    if (code == 3) chk(rd(a2) == p2, "R7", "protected entry untouched", rd(a2), p2);
    if (wr) begin
      int slot;
      slot = -1;
      for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) slot = i;
      if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % 8; end
      m_v[slot] = 1; m_vpn[slot] = vpn; m_ppn[slot] = ppn; m_d[slot] = newp[29];
    end
    in_txn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R12 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (m_v[i]) m_v[i] = 0;
    map_page(32'h00123, 32'h00A5, 1);
    map_page(32'h1F000, 32'h7FFF, 1);
    map_page(32'h7FFFF, 32'h0001, 0);
    for (int i = 0; i < 9; i++) map_page(32'h20000 + i, 32'h100 + i, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_rd_en && !mem_wr_en, "R1", "reset outputs",
        {req_ready, resp_valid, mem_rd_en, mem_wr_en}, 4'b1000);
    started = 1;

    req(32'h00123, 32'h456, 0, "R4");        // walk, load
    req(32'h00123, 32'hFFF, 0, "R3");        // hit, top offset
    pt[TBL0 + 32'h123 * 4] = 32'h8000_0000 | (1 << 28) | 32'h0333;
    req(32'h00123, 32'h000, 0, "R3");        // stale hit, no memory read
    req(32'h00123, 32'h010, 1, "R9");        // store on clean entry walks
    req(32'h00123, 32'h014, 1, "R9");        // now hits
    req(32'h1F000, 32'h800, 1, "R4");        // store walk, max page number
    req(32'h01400, 32'h004, 0, "R5");        // first level missing
    req(32'h003FF, 32'h008, 1, "R6");        // page missing
    req(32'h7FFFF, 32'hABC, 1, "R7");        // write protected
    req(32'h7FFFF, 32'hABC, 0, "R8");        // load to read-only page works
    do_flush();
    req(32'h00123, 32'h020, 0, "R10");       // must walk again
    do_flush();
    for (int i = 0; i < 9; i++) req(32'h20000 + i, 32'h100 * i, 0, "R11");
    req(32'h20001, 32'h044, 0, "R11");       // still cached
    req(32'h20000, 32'h048, 0, "R11");       // evicted, walks
    req(32'h20008, 32'h04C, 0, "R11");       // still cached

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule